// File: doc/BRIEF.md
# Block-Transfer Register Walker

This block steps through the register list of a multi-register load or store instruction. A 16-bit mask is captured when the load strobe is asserted. Each bit stands for one register. The block then presents the lowest-numbered register that has not yet been handled. Register selection for bus reads and for register-file writes takes that number during the transfer. Each advance strobe retires the presented register, and a flag reports when none remain.

Alongside the walk, the block drives a 32-bit operand onto the A bus for the address arithmetic. That operand is built from the number of registers in the list, times four. A 2-bit selector also lets it give the constant 3, either alone or as the two low bits of the scaled count. The constant 3, together with a borrow in the ALU, takes 4 off the link register. The scaled count, with or without the low bits, sets the start address of the transfer.

Top module: `reglist_sequencer`

## Requirements
- R1: While reset is held and after it is released, no register is pending: `done_o` is 1, `cur_reg_o` is 0 and the stored register count is 0.
- R2: The clock edge at which `load_i` is 1 captures `list_i` as the pending set. From the following cycle, `cur_reg_o` gives the index of the lowest set bit of the pending set, and `done_o` is 0 when the set is non-empty. With no strobe, both outputs hold their value.
- R3: A clock edge at which `step_i` is 1, `load_i` is 0 and `done_o` is 0 clears the lowest pending bit. Registers are therefore presented in strictly ascending index order.
- R4: `done_o` is 1 exactly when no pending bit remains. This includes the cycle after an all-zero list is loaded and the cycle after the last register is stepped past.
- R5: `step_i` while `done_o` is 1 has no effect: `done_o` stays 1 and the A-bus count value is unchanged.
- R6: When `load_i` and `step_i` are both 1 at one edge, the load wins. The new list is captured whole and no bit of it is cleared.
- R7: `abus_sel_i` = 0 gives `abus_o` = 0 and `abus_drive_o` = 0.
- R8: `abus_sel_i` = 1 gives `abus_o` = 3 and `abus_drive_o` = 1.
- R9: `abus_sel_i` = 2 gives `abus_o` = 4 × (number of set bits in the list as loaded) and `abus_drive_o` = 1. This value does not change as registers are stepped past.
- R10: `abus_sel_i` = 3 gives `abus_o` = 4 × count + 3 and `abus_drive_o` = 1.
- R11: While `done_o` is 1, `cur_reg_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture `list_i` as the new pending set |
| list_i | input | 16 | Register mask, bit n is register n |
| step_i | input | 1 | Retire the presented register |
| abus_sel_i | input | 2 | A-bus operand selector (0 off, 1 constant 3, 2 count×4, 3 count×4+3) |
| cur_reg_o | output | 4 | Lowest pending register index |
| done_o | output | 1 | No register pending |
| abus_o | output | 32 | A-bus operand |
| abus_drive_o | output | 1 | A-bus operand is being driven |

## Verification
The pending set and the captured count are the only state, and each changes at the clock edge where the strobe is sampled. The A-bus operand depends on the selector with no register in between. The bench therefore drives every strobe and selector at a falling edge and lets one rising edge pass. It then reads `cur_reg_o`, `done_o` and `abus_o` at the next falling edge, one cycle after the stimulus. Selector changes are read at the falling edge after they are applied, with no rising edge needed.

// File: rtl/rls_pkg.sv
package rls_pkg;

  typedef enum logic [1:0] {
    ABUS_OFF        = 2'd0,
    ABUS_THREE      = 2'd1,
    ABUS_COUNT      = 2'd2,
    ABUS_COUNT_OR3  = 2'd3
  } abus_mode_e;

endpackage

// File: rtl/rls_lowest_one.sv
module rls_lowest_one #(
  parameter int W = 16,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic [W-1:0]     onehot_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);

  // seen[i] is set when some bit below i is set
  logic [W:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_chain
    assign seen[i+1]   = seen[i] | vec_i[i];
    assign onehot_o[i] = vec_i[i] & ~seen[i];
  end

  assign any_o = seen[W];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (onehot_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

endmodule

// File: rtl/rls_popcount.sv
module rls_popcount #(
  parameter int W = 16,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      cnt_o = cnt_o + CNT_W'(vec_i[i]);
    end
  end

endmodule

// File: rtl/rls_abus_format.sv
module rls_abus_format
  import rls_pkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int ABUS_W = 32,
  localparam int PAD_W = ABUS_W - CNT_W - 2
) (
  input  abus_mode_e        mode_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [ABUS_W-1:0] value_o,
  output logic              drive_o
);

  logic [ABUS_W-1:0] scaled;

  assign scaled = {{PAD_W{1'b0}}, cnt_i, 2'b00};

  always_comb begin
    value_o = '0;
    drive_o = 1'b1;
    unique case (mode_i)
      ABUS_OFF:       drive_o = 1'b0;
      ABUS_THREE:     value_o = ABUS_W'(3);
      ABUS_COUNT:     value_o = scaled;
      ABUS_COUNT_OR3: value_o = scaled | ABUS_W'(3);
      default:        drive_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/reglist_sequencer.sv
module reglist_sequencer
  import rls_pkg::*;
#(
  parameter int LIST_W = 16,
  parameter int ABUS_W = 32,
  localparam int IDX_W = $clog2(LIST_W),
  localparam int CNT_W = $clog2(LIST_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [LIST_W-1:0] list_i,
  input  logic              step_i,
  input  logic [1:0]        abus_sel_i,
  output logic [IDX_W-1:0]  cur_reg_o,
  output logic              done_o,
  output logic [ABUS_W-1:0] abus_o,
  output logic              abus_drive_o
);

  logic [LIST_W-1:0] pending_q, pending_d;
  logic [CNT_W-1:0]  count_q, count_d;
  logic [LIST_W-1:0] lowest_oh;
  logic [IDX_W-1:0]  lowest_idx;
  logic              any_pending;
  logic [CNT_W-1:0]  list_cnt;
  logic              pend_en, cnt_en;

  rls_lowest_one #(.W(LIST_W)) u_lowest (
    .vec_i    (pending_q),
    .onehot_o (lowest_oh),
    .idx_o    (lowest_idx),
    .any_o    (any_pending)
  );

  rls_popcount #(.W(LIST_W)) u_count (
    .vec_i (list_i),
    .cnt_o (list_cnt)
  );

  // next state: load has priority over step
  always_comb begin
    pending_d = pending_q;
    count_d   = count_q;
    pend_en   = 1'b0;
    cnt_en    = 1'b0;
    if (load_i) begin
      pending_d = list_i;
      count_d   = list_cnt;
      pend_en   = 1'b1;
      cnt_en    = 1'b1;
    end else if (step_i && any_pending) begin
      pending_d = pending_q & ~lowest_oh;
      pend_en   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= '0;
    end else if (pend_en) begin
      pending_q <= pending_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (cnt_en) begin
      count_q <= count_d;
    end
  end

  assign cur_reg_o = lowest_idx;
  assign done_o    = ~any_pending;

  rls_abus_format #(.CNT_W(CNT_W), .ABUS_W(ABUS_W)) u_abus (
    .mode_i  (abus_mode_e'(abus_sel_i)),
    .cnt_i   (count_q),
    .value_o (abus_o),
    .drive_o (abus_drive_o)
  );

endmodule

// File: rtl/reglist_sequencer_chk.sv
module reglist_sequencer_chk #(
  parameter int LIST_W = 16,
  parameter int ABUS_W = 32,
  localparam int IDX_W = $clog2(LIST_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic [LIST_W-1:0] list_i,
  input logic              step_i,
  input logic [1:0]        abus_sel_i,
  input logic [IDX_W-1:0]  cur_reg_o,
  input logic              done_o,
  input logic [ABUS_W-1:0] abus_o,
  input logic              abus_drive_o
);

  AST_LOAD_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && list_i != '0) |=> !done_o);  // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> ($stable(cur_reg_o) && $stable(done_o)));  // R2

  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && !done_o) |=> (done_o || cur_reg_o > $past(cur_reg_o)));  // R3

  AST_LOAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && list_i == '0) |=> done_o);  // R4

  AST_STEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && done_o) |=> done_o);  // R5

  AST_SEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (abus_sel_i == 2'd0) |-> (abus_o == '0 && !abus_drive_o));  // R7

  AST_SEL_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    (abus_sel_i == 2'd1) |-> (abus_o == ABUS_W'(3) && abus_drive_o));  // R8

  AST_COUNT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (abus_sel_i == 2'd2) |-> (abus_o[1:0] == 2'b00 && abus_drive_o));  // R9

  AST_COUNT_LOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (abus_sel_i == 2'd3) |-> (abus_o[1:0] == 2'b11 && abus_drive_o));  // R10

  AST_IDLE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cur_reg_o == '0));  // R11

endmodule

bind reglist_sequencer reglist_sequencer_chk #(.LIST_W(LIST_W), .ABUS_W(ABUS_W)) u_chk (.*);

// File: tb/reglist_sequencer_test.sv
`timescale 1ns/1ps
module reglist_sequencer_test;

  logic        clk;
  logic        rst_n;
  logic        load_i;
  logic [15:0] list_i;
  logic        step_i;
  logic [1:0]  abus_sel_i;
  logic [3:0]  cur_reg_o;
  logic        done_o;
  logic [31:0] abus_o;
  logic        abus_drive_o;

  int n_checks = 0;
  int n_fails  = 0;

  reglist_sequencer uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .list_i       (list_i),
    .step_i       (step_i),
    .abus_sel_i   (abus_sel_i),
    .cur_reg_o    (cur_reg_o),
    .done_o       (done_o),
    .abus_o       (abus_o),
    .abus_drive_o (abus_drive_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int ones(input logic [15:0] v);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  // apply a strobe at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic cycle(input logic ld, input logic [15:0] lst, input logic st);
    @(negedge clk);
    load_i = ld;
    list_i = lst;
    step_i = st;
    @(negedge clk);
    load_i = 1'b0;
    step_i = 1'b0;
  endtask

  task automatic t_reset();
    abus_sel_i = 2'd2;
    #1;
    chk("R1 done", 32'(done_o), 32'd1);
    chk("R1 cur_reg", 32'(cur_reg_o), 32'd0);
    chk("R1 count", abus_o, 32'd0);
    chk("R11 idle index", 32'(cur_reg_o), 32'd0);
  endtask

  task automatic t_walk(input logic [15:0] lst);
    abus_sel_i = 2'd2;
    cycle(1'b1, lst, 1'b0);
    for (int i = 0; i < 16; i++) begin
      if (lst[i]) begin
        chk("R2/R3 cur_reg", 32'(cur_reg_o), 32'(i));
        chk("R4 not done", 32'(done_o), 32'd0);
        chk("R9 count steady", abus_o, 32'(ones(lst) * 4));
        cycle(1'b0, 16'h0, 1'b1);
      end
    end
    chk("R4 done at end", 32'(done_o), 32'd1);
    chk("R11 index when done", 32'(cur_reg_o), 32'd0);
  endtask

  task automatic t_zero();
    cycle(1'b1, 16'h0, 1'b0);
    chk("R4 empty load", 32'(done_o), 32'd1);
  endtask

  task automatic t_step_idle();
    abus_sel_i = 2'd2;
    cycle(1'b1, 16'h0300, 1'b0);
    cycle(1'b0, 16'h0, 1'b1);
    cycle(1'b0, 16'h0, 1'b1);
    for (int k = 0; k < 3; k++) cycle(1'b0, 16'h0, 1'b1);
    chk("R5 done stays", 32'(done_o), 32'd1);
    chk("R5 count kept", abus_o, 32'd8);
  endtask

  task automatic t_hold();
    cycle(1'b1, 16'h0140, 1'b0);
    for (int k = 0; k < 4; k++) @(negedge clk);
    chk("R2 hold cur_reg", 32'(cur_reg_o), 32'd6);
    chk("R2 hold done", 32'(done_o), 32'd0);
  endtask

  task automatic t_priority();
    abus_sel_i = 2'd2;
    cycle(1'b1, 16'h00F0, 1'b0);
    cycle(1'b0, 16'h0, 1'b1);
    chk("R3 advanced", 32'(cur_reg_o), 32'd5);
    cycle(1'b1, 16'h0C02, 1'b1);
    chk("R6 load wins", 32'(cur_reg_o), 32'd1);
    chk("R6 new count", abus_o, 32'd12);
  endtask

  task automatic t_sel();
    cycle(1'b1, 16'h1F00, 1'b0);
    abus_sel_i = 2'd0; @(negedge clk);
    chk("R7 value", abus_o, 32'd0);
    chk("R7 drive", 32'(abus_drive_o), 32'd0);
    abus_sel_i = 2'd1; @(negedge clk);
    chk("R8 value", abus_o, 32'd3);
    chk("R8 drive", 32'(abus_drive_o), 32'd1);
    abus_sel_i = 2'd2; @(negedge clk);
    chk("R9 value", abus_o, 32'd20);
    abus_sel_i = 2'd3; @(negedge clk);
    chk("R10 value", abus_o, 32'd23);
    chk("R10 drive", 32'(abus_drive_o), 32'd1);
    cycle(1'b1, 16'hFFFF, 1'b0);
    chk("R10 full list", abus_o, 32'd67);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_i = 1'b0; step_i = 1'b0; list_i = '0; abus_sel_i = 2'd2;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_walk(16'hA5C3);
    t_walk(16'h8000);
    t_walk(16'h0001);
    t_walk(16'hFFFF);
    t_zero();
    t_step_idle();
    t_hold();
    t_priority();
    t_sel();
    summary();
    $finish;
  end

endmodule